// File: doc/BRIEF.md
# Delay-Slot Branch Resolution Unit

This unit decides conditional branches for a 32-bit processor whose branches carry an architectural delay slot. A one-hot branch-kind vector picks the condition. The unit compares two operands as signed integers and raises equal, greater-than and less-than flags. From those flags and the selected kind it produces a taken or a not-taken indication. It also computes the branch target from a sign-extended word offset.

The unit presents three successive program counters: the branch itself, the delay-slot instruction that always runs, and the address to fetch after the slot. The third is the branch target when the branch is taken. Otherwise it is the sequential address after the slot. A decode vector that is not exactly one-hot raises an error output and suppresses both decision outputs.

All logic is combinational. A parameter adds one register stage at the outputs for timing.

Top module: `brres_top`

## Requirements
- R1: The kind vector `br_sel` uses bit 0 = equal, bit 1 = not-equal, bit 2 = a<0, bit 3 = a<=0, bit 4 = a>0, bit 5 = a>=0. Any pattern without exactly one bit set drives `decode_err` high and both `taken` and `not_taken` low. A one-hot pattern drives `decode_err` low.
- R2: `flag_eq`, `flag_gt` and `flag_lt` compare operand a with the effective operand b as signed two's-complement values. Exactly one of the three flags is high.
- R3: For the zero-compare kinds (bits 2 to 5), the effective operand b is zero, and the value on `opnd_b` has no effect on any output.
- R4: The equal kind is taken exactly when a equals b. The not-equal kind is taken exactly when they differ.
- R5: The zero-compare kinds are taken exactly when signed a is <0, <=0, >0 or >=0 respectively.
- R6: For a valid decode, exactly one of `taken` and `not_taken` is high.
- R7: `target_pc` equals next_pc plus the sign-extended offset shifted left by two, modulo 2^XLEN. This holds for every decode.
- R8: `fetch_pc` equals `target_pc` when `taken` is high. Otherwise it equals next_pc + 4, modulo 2^XLEN, including on an invalid decode.
- R9: `cur_pc` carries pc and `slot_pc` carries next_pc unchanged, so the delay-slot instruction always runs whether or not the branch is taken.
- R10: With REG_OUT=1, every output reflects the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| br_sel | input | 6 | One-hot branch kind |
| opnd_a | input | XLEN | First operand |
| opnd_b | input | XLEN | Second operand (equality kinds only) |
| offset | input | OFFW | Signed word offset |
| pc | input | XLEN | Address of the branch |
| next_pc | input | XLEN | Address of the delay-slot instruction |
| flag_eq | output | 1 | a equals effective b |
| flag_gt | output | 1 | a greater than effective b, signed |
| flag_lt | output | 1 | a less than effective b, signed |
| taken | output | 1 | Branch condition met |
| not_taken | output | 1 | Branch condition not met |
| decode_err | output | 1 | Kind vector not one-hot |
| target_pc | output | XLEN | Computed branch target |
| cur_pc | output | XLEN | Branch address |
| slot_pc | output | XLEN | Delay-slot address |
| fetch_pc | output | XLEN | Address fetched after the delay slot |

## Verification
The bench builds the unit with XLEN=8, OFFW=4 and REG_OUT=1. At this size, every value of operand a can be swept against equal, adjacent and unrelated b values for all six kinds. All 64 kind patterns can be tried, and every offset can be reached. The narrow program counters make wraparound of both the target adder and the sequential adder easy to hit at the ends of the address space. The registered build also exposes the one-cycle latency and the clearing of the outputs by reset.

// File: rtl/brres_pkg.sv
package brres_pkg;

    localparam int NKIND = 6;

    typedef enum int unsigned {
        BK_EQ  = 0,
        BK_NE  = 1,
        BK_LTZ = 2,
        BK_LEZ = 3,
        BK_GTZ = 4,
        BK_GEZ = 5
    } br_kind_e;

    typedef logic [NKIND-1:0] br_sel_t;

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } cmp_flags_t;

    // True for a vector with exactly one bit set
    function automatic logic sel_onehot(br_sel_t s);
        return (s != '0) && ((s & (s - 1'b1)) == '0);
    endfunction

    // Kinds that compare against the second register operand
    function automatic logic sel_uses_b(br_sel_t s);
        return s[BK_EQ] | s[BK_NE];
    endfunction

    // Condition evaluation over the comparison flags
    function automatic logic cond_hit(br_sel_t s, cmp_flags_t f);
        return (s[BK_EQ]  &  f.eq)
             | (s[BK_NE]  & ~f.eq)
             | (s[BK_LTZ] &  f.lt)
             | (s[BK_LEZ] & (f.lt | f.eq))
             | (s[BK_GTZ] &  f.gt)
             | (s[BK_GEZ] & (f.gt | f.eq));
    endfunction

endpackage

// File: rtl/brres_cmp.sv
module brres_cmp
    import brres_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output cmp_flags_t   flags
);
    logic is_eq;
    logic is_lt;

    always_comb begin
        is_eq    = (a == b);
        is_lt    = ($signed(a) < $signed(b));
        flags.eq = is_eq;
        flags.lt = is_lt;
        flags.gt = ~is_eq & ~is_lt;
    end
endmodule

// File: rtl/brres_dec.sv
module brres_dec
    import brres_pkg::*;
(
    input  br_sel_t    sel,
    input  cmp_flags_t flags,
    output logic       valid,
    output logic       taken,
    output logic       not_taken
);
    logic hit;

    always_comb begin
        valid     = sel_onehot(sel);
        hit       = cond_hit(sel, flags);
        taken     = valid & hit;
        not_taken = valid & ~hit;
    end
endmodule

// File: rtl/brres_tgt.sv
module brres_tgt #(
    parameter int W  = 32,
    parameter int OW = 16
) (
    input  logic [W-1:0]  base,
    input  logic [OW-1:0] off,
    output logic [W-1:0]  target,
    output logic [W-1:0]  seq
);
    localparam int EXT = W - OW;

    logic [W-1:0] off_ext;
    logic [W-1:0] off_bytes;

    always_comb begin
        off_ext   = {{EXT{off[OW-1]}}, off};
        off_bytes = {off_ext[W-3:0], 2'b00};
        target    = base + off_bytes;
        seq       = base + W'(4);
    end
endmodule

// File: rtl/brres_top.sv
module brres_top
    import brres_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int OFFW    = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NKIND-1:0]  br_sel,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [OFFW-1:0]   offset,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   next_pc,
    output logic              flag_eq,
    output logic              flag_gt,
    output logic              flag_lt,
    output logic              taken,
    output logic              not_taken,
    output logic              decode_err,
    output logic [XLEN-1:0]   target_pc,
    output logic [XLEN-1:0]   cur_pc,
    output logic [XLEN-1:0]   slot_pc,
    output logic [XLEN-1:0]   fetch_pc
);
    typedef struct packed {
        cmp_flags_t      flags;
        logic            taken;
        logic            not_taken;
        logic            err;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] cur;
        logic [XLEN-1:0] slot;
        logic [XLEN-1:0] fetch;
    } res_t;

    br_sel_t         sel;
    logic [XLEN-1:0] b_eff;
    cmp_flags_t      flags;
    logic            valid;
    logic            tk;
    logic            ntk;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] seq;
    res_t            res_d;
    res_t            res_o;

    assign sel   = br_sel;
    assign b_eff = sel_uses_b(sel) ? opnd_b : '0;

    brres_cmp #(.W(XLEN)) u_cmp (
        .a     (opnd_a),
        .b     (b_eff),
        .flags (flags)
    );

    brres_dec u_dec (
        .sel       (sel),
        .flags     (flags),
        .valid     (valid),
        .taken     (tk),
        .not_taken (ntk)
    );

    brres_tgt #(.W(XLEN), .OW(OFFW)) u_tgt (
        .base   (next_pc),
        .off    (offset),
        .target (tgt),
        .seq    (seq)
    );

    always_comb begin
        res_d.flags     = flags;
        res_d.taken     = tk;
        res_d.not_taken = ntk;
        res_d.err       = ~valid;
        res_d.target    = tgt;
        res_d.cur       = pc;
        res_d.slot      = next_pc;
        res_d.fetch     = tk ? tgt : seq;
    end

    generate
        if (REG_OUT) begin : g_reg
            res_t res_q;
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res_d;
            end
            assign res_o = res_q;
        end else begin : g_comb
            assign res_o = res_d;
        end
    endgenerate

    assign flag_eq    = res_o.flags.eq;
    assign flag_gt    = res_o.flags.gt;
    assign flag_lt    = res_o.flags.lt;
    assign taken      = res_o.taken;
    assign not_taken  = res_o.not_taken;
    assign decode_err = res_o.err;
    assign target_pc  = res_o.target;
    assign cur_pc     = res_o.cur;
    assign slot_pc    = res_o.slot;
    assign fetch_pc   = res_o.fetch;
endmodule

// File: rtl/brres_chk.sv
module brres_chk #(
    parameter int XLEN    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] next_pc,
    input logic            flag_eq,
    input logic            flag_gt,
    input logic            flag_lt,
    input logic            taken,
    input logic            not_taken,
    input logic            decode_err,
    input logic [XLEN-1:0] target_pc,
    input logic [XLEN-1:0] slot_pc,
    input logic [XLEN-1:0] fetch_pc
);
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R1
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        decode_err |-> (!taken && !not_taken));

    // R2
    flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        primed |-> ($countones({flag_eq, flag_gt, flag_lt}) == 1));

    // R6
    decision_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && !decode_err) |-> (taken != not_taken));

    // R8
    taken_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        taken |-> (fetch_pc == target_pc));

    // R8
    fallthru_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && !taken) |-> (fetch_pc == slot_pc + XLEN'(4)));

    generate
        if (REG_OUT) begin : g_lat
            // R9
            slot_follow_chk: assert property (@(posedge clk) disable iff (rst)
                primed |-> (slot_pc == $past(next_pc)));
        end else begin : g_now
            // R9
            slot_follow_chk: assert property (@(posedge clk) disable iff (rst)
                slot_pc == next_pc);
        end
    endgenerate
endmodule

bind brres_top brres_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .next_pc    (next_pc),
    .flag_eq    (flag_eq),
    .flag_gt    (flag_gt),
    .flag_lt    (flag_lt),
    .taken      (taken),
    .not_taken  (not_taken),
    .decode_err (decode_err),
    .target_pc  (target_pc),
    .slot_pc    (slot_pc),
    .fetch_pc   (fetch_pc)
);

// File: tb/sim_brres_top.sv
`timescale 1ns/1ps
module sim_brres_top;
    localparam int XLEN = 8;
    localparam int OFFW = 4;
    localparam int MASK = (1 << XLEN) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [5:0]      br_sel = '0;
    logic [XLEN-1:0] opnd_a = '0, opnd_b = '0, pc = '0, next_pc = '0;
    logic [OFFW-1:0] offset = '0;
    logic            flag_eq, flag_gt, flag_lt, taken, not_taken, decode_err;
    logic [XLEN-1:0] target_pc, cur_pc, slot_pc, fetch_pc;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    brres_top #(.XLEN(XLEN), .OFFW(OFFW), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .br_sel(br_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .offset(offset), .pc(pc), .next_pc(next_pc),
        .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_lt(flag_lt),
        .taken(taken), .not_taken(not_taken), .decode_err(decode_err),
        .target_pc(target_pc), .cur_pc(cur_pc), .slot_pc(slot_pc), .fetch_pc(fetch_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sgn(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    function automatic bit want_taken(input int k, input int sa, input int sb);
        case (k)
            0: return sa == sb;
            1: return sa != sb;
            2: return sa < 0;
            3: return sa <= 0;
            4: return sa > 0;
            default: return sa >= 0;
        endcase
    endfunction

    task automatic drive(input int sel, input int a, input int b, input int off,
                         input int p, input int np);
        br_sel  = 6'(sel);
        opnd_a  = XLEN'(a);
        opnd_b  = XLEN'(b);
        offset  = OFFW'(off);
        pc      = XLEN'(p);
        next_pc = XLEN'(np);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R10: reset clears every output
        repeat (2) @(posedge clk);
        #1;
        chk("R10 reset flags", {flag_eq, flag_gt, flag_lt, taken, not_taken, decode_err}, 0);
        chk("R10 reset pcs", {target_pc, cur_pc, slot_pc, fetch_pc}, 0);
        rst = 1'b0;

        // Sweep all kinds, all values of a, several b choices
        for (int k = 0; k < 6; k++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 4; j++) begin
                    int b, np, p, off, sa, sbe, tgt, seqv;
                    bit tk;
                    case (j)
                        0: b = a;
                        1: b = (a + 1) & MASK;
                        2: b = (a - 1) & MASK;
                        default: b = (a * 37 + 11) & MASK;
                    endcase
                    np   = (a * 5 + k * 3) & MASK;
                    p    = (np - 4) & MASK;
                    off  = (a + j) & 15;
                    drive(1 << k, a, b, off, p, np);
                    sa   = sgn(a, XLEN);
                    sbe  = (k < 2) ? sgn(b, XLEN) : 0;
                    tk   = want_taken(k, sa, sgn(b, XLEN));
                    tgt  = (np + sgn(off, OFFW) * 4) & MASK;
                    seqv = (np + 4) & MASK;
                    if (k < 2) chk("R2 flags", {flag_eq, flag_gt, flag_lt},
                                   {29'd0, sa == sbe, sa > sbe, sa < sbe});
                    else       chk("R3 zero-compare flags ignore b", {flag_eq, flag_gt, flag_lt},
                                   {29'd0, sa == 0, sa > 0, sa < 0});
                    if (k < 2) chk("R4 eq/ne decision", taken, tk);
                    else       chk("R5 sign decision", taken, tk);
                    chk("R6 one-hot decision", {taken, not_taken}, {30'd0, tk, !tk});
                    chk("R1 valid decode", decode_err, 0);
                    chk("R7 target", target_pc, tgt);
                    chk("R8 fetch after slot", fetch_pc, tk ? tgt : seqv);
                    chk("R9 pc chain", {cur_pc, slot_pc}, {16'd0, p[7:0], np[7:0]});
                end
            end
        end

        // R1: all non-one-hot kind patterns
        for (int s = 0; s < 64; s++) begin
            if ($countones(s) != 1) begin
                drive(s, s * 3, s, s & 15, 8'h40, 8'hFC);
                chk("R1 bad decode err", decode_err, 1);
                chk("R1 bad decode quiet", {taken, not_taken}, 0);
                chk("R8 fetch on bad decode", fetch_pc, 8'h00);
            end
        end

        // R7 wrap: npc 0x10, offset -8 -> 0xF0
        drive(1, 5, 5, 8, 8'h0C, 8'h10);
        chk("R7 backward wrap", target_pc, 8'hF0);
        chk("R8 taken uses target", fetch_pc, 8'hF0);
        // R7 wrap: npc 0xF0, offset +7 -> 0x0C
        drive(1 << 4, 1, 0, 7, 8'hEC, 8'hF0);
        chk("R7 forward wrap", target_pc, 8'h0C);
        // R3: b extremes with zero-compare kind on a = 0
        drive(1 << 3, 0, 8'h80, 0, 0, 4);
        chk("R3 b ignored lez", taken, 1);
        drive(1 << 3, 0, 8'h7F, 0, 0, 4);
        chk("R3 b ignored lez alt", taken, 1);

        // R10: output holds until the next edge
        br_sel = 6'd1; next_pc = 8'h33;
        #1;
        chk("R10 holds before edge", slot_pc, 8'h04);
        @(posedge clk);
        #1;
        chk("R10 updates after edge", slot_pc, 8'h33);
        // R10: reset mid-run
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 reset clears", {slot_pc, fetch_pc, 8'd0, 2'd0, taken, not_taken, decode_err, 3'd0}, 0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule